// File: doc/BRIEF.md
# Missing-Tooth Crank Angle Tracker

The tracker follows the crankshaft through a complete four-stroke cycle (720 crank degrees, two revolutions). Its inputs are a toothed crank wheel signal and a conditioned cam level. The crank wheel has `cfg_teeth` evenly spaced tooth positions per revolution. Of these, `cfg_missing` consecutive teeth are absent, which leaves one long gap per revolution. The block finds that gap by comparing tooth periods and counts the teeth between gaps. It samples the cam level at each gap to tell the two crank revolutions apart. Between tooth edges it fills in the angle with interpolated ticks, so a downstream scheduler sees a position that advances smoothly.

Each tooth position is worth `2**LOG_TPT` ticks, so one full cycle is `2*cfg_teeth*2**LOG_TPT` ticks. The gap-ending tooth is tooth 0 of its revolution. A high cam level at that tooth marks the first half of the cycle, and a low cam level marks the second half. Position outputs are meaningful only while `sync_stopped` is low. The flag goes low once two gaps in a row show a correct tooth count and opposite cam levels, and it goes high again on any inconsistency.

Top module: `crk_angle_tracker`

## Requirements
- R1: While reset is applied and right after it, `sync_stopped` is 1, `angle_ticks` is 0 and `tick_stb` is 0.
- R2: A tooth edge counts as a gap edge when the interval that ends at it is more than 1.5 times the reference interval. The reference interval is the most recent interval that was not a gap. The first two edges after reset are never gap edges.
- R3: At a gap edge, the number of tooth edges since the previous gap edge, counting that earlier edge, must equal `cfg_teeth - cfg_missing`. If it does not, `sync_stopped` rises and counting restarts from the current gap.
- R4: `sync_stopped` falls only at a gap edge. That gap and the gap before it must both have a correct count under R3, and the cam level sampled at the two gaps must differ.
- R5: At a gap edge while locked, `angle_ticks` becomes 0 if the cam level is 1 and `cfg_teeth * 2**LOG_TPT` if the cam level is 0.
- R6: The k-th tooth edge after a gap edge (k = 1 .. `cfg_teeth-cfg_missing-1`) sets `angle_ticks` to the half-cycle base plus `k * 2**LOG_TPT`.
- R7: Between edges, `angle_ticks` rises by one every `ref_interval >> LOG_TPT` clocks, counted from the edge. It stops after `2**LOG_TPT - 1` ticks after a normal tooth, and after `(cfg_missing+1) * 2**LOG_TPT - 1` ticks after the last tooth before the gap. It never reaches `2*cfg_teeth*2**LOG_TPT`.
- R8: While `sync_stopped` is 1, `angle_ticks` stays 0 and `tick_stb` stays 0.
- R9: A non-gap edge that would make the tooth count exceed `cfg_teeth - cfg_missing` raises `sync_stopped`. Relock then needs three further gap edges.
- R10: A gap with a correct count but the same cam level as the previous gap raises `sync_stopped` while locked. That gap counts as the first good gap, so one more alternating gap relocks.
- R11: `tick_stb` is high for exactly the cycles in which a locked `angle_ticks` shows a new value.
- R12: A rising crank edge shows on the outputs `SYNC_STAGES + 1` clock edges after the input is sampled high. The outputs do not change before that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crank_tooth | input | 1 | Digitised crank tooth pulse, rising edge marks a tooth |
| cam_level | input | 1 | Conditioned cam level, high at every other gap |
| cfg_teeth | input | TOOTH_W | Tooth positions per revolution (N) |
| cfg_missing | input | TOOTH_W | Consecutive missing teeth forming the gap (M) |
| angle_ticks | output | TOOTH_W+LOG_TPT+1 | Absolute angle over the cycle in ticks |
| tick_stb | output | 1 | One-cycle strobe when a locked angle takes a new value |
| sync_stopped | output | 1 | High until lock is established and while it is lost |

## Verification
The bench drives the wheel pattern tooth by tooth for three wheel shapes. A tooth-level model of the lock rules predicts the angle at several points in every tooth. The lock sequence is started partway through a revolution, so a tracker that locked on the first gap would show an early angle. A dropped tooth looks like a short gap with a bad count. A design that trusted the period ratio alone would keep reporting a shifted angle. A revolution with the gap filled in tests tooth-count overflow, and a tracker without that check would run its angle past the cycle end. Two same-level cam gaps in a row test the alternation rule. The long interpolation run across the gap is checked to stop one tick short of the next gap-ending tooth. A tracker that used the gap interval as its reference would tick too slowly on the first tooth of the next revolution.

// File: rtl/crk_pkg.sv
package crk_pkg;
   typedef enum logic [1:0] {
      LK_IDLE = 2'd0,
      LK_SEEN = 2'd1,
      LK_ONE  = 2'd2,
      LK_LOCK = 2'd3
   } lock_st_t;
endpackage

// File: rtl/crk_edge_timer.sv
module crk_edge_timer #(
   parameter int PERIOD_W    = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                crank_in,
   input  logic                cam_in,
   output logic                rise,
   output logic                gap,
   output logic                cam_at_edge,
   output logic [PERIOD_W-1:0] ref_period
);
   logic [SYNC_STAGES-1:0] crk_sr;
   logic [SYNC_STAGES-1:0] cam_sr;
   logic                   crk_prev;
   logic [PERIOD_W-1:0]    per_cnt;
   logic                   started;
   logic                   ref_valid;
   logic [PERIOD_W+1:0]    cur_x2;
   logic [PERIOD_W+1:0]    ref_x3;

   generate
      if (SYNC_STAGES == 1) begin : g_one_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               crk_sr <= '0;
               cam_sr <= '0;
            end else begin
               crk_sr <= crank_in;
               cam_sr <= cam_in;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               crk_sr <= '0;
               cam_sr <= '0;
            end else begin
               crk_sr <= {crk_sr[SYNC_STAGES-2:0], crank_in};
               cam_sr <= {cam_sr[SYNC_STAGES-2:0], cam_in};
            end
         end
      end
   endgenerate

   assign rise        = crk_sr[SYNC_STAGES-1] & ~crk_prev;
   assign cam_at_edge = cam_sr[SYNC_STAGES-1];
   assign cur_x2      = {1'b0, per_cnt, 1'b0};
   assign ref_x3      = {2'b00, ref_period} + {1'b0, ref_period, 1'b0};
   assign gap         = rise & ref_valid & (cur_x2 > ref_x3);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crk_prev   <= 1'b0;
         per_cnt    <= '0;
         started    <= 1'b0;
         ref_valid  <= 1'b0;
         ref_period <= '0;
      end else begin
         crk_prev <= crk_sr[SYNC_STAGES-1];
         if (rise) begin
            per_cnt <= PERIOD_W'(1);
            started <= 1'b1;
            if (started && !gap) begin
               ref_period <= per_cnt;
               ref_valid  <= 1'b1;
            end
         end else if (per_cnt != '1) begin
            per_cnt <= per_cnt + 1'b1;
         end
      end
   end

   // R2: a gap interval must not replace the reference interval
   a_r2_ref_held_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
      gap |=> $stable(ref_period));
endmodule

// File: rtl/crk_sync_fsm.sv
module crk_sync_fsm
   import crk_pkg::*;
#(
   parameter int TOOTH_W = 7,
   parameter int LOG_TPT = 2,
   parameter int ANGLE_W = TOOTH_W + LOG_TPT + 1,
   parameter int LIM_W   = TOOTH_W + LOG_TPT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rise,
   input  logic               gap,
   input  logic               cam,
   input  logic [TOOTH_W-1:0] cfg_teeth,
   input  logic [TOOTH_W-1:0] cfg_missing,
   output logic               locked,
   output logic               lock_nx,
   output logic [ANGLE_W-1:0] pos_nx,
   output logic [LIM_W-1:0]   tick_lim
);
   localparam int TPT = 1 << LOG_TPT;

   lock_st_t           state, st_nx;
   logic [TOOTH_W-1:0] idx, idx_nx, last_idx;
   logic               half, half_nx, prev_cam;
   logic               count_ok, alt;
   logic [ANGLE_W-1:0] tooth_sum;
   logic [LIM_W-1:0]   gap_lim, lim_nx;

   assign last_idx = cfg_teeth - cfg_missing - 1'b1;
   assign count_ok = (idx == last_idx);
   assign alt      = (cam != prev_cam);
   assign locked   = (state == LK_LOCK);

   always_comb begin
      st_nx   = state;
      idx_nx  = idx;
      half_nx = half;
      if (rise) begin
         if (gap) begin
            idx_nx  = '0;
            half_nx = ~cam;
            unique case (state)
               LK_IDLE: st_nx = LK_SEEN;
               LK_SEEN: st_nx = count_ok ? LK_ONE : LK_SEEN;
               LK_ONE,
               LK_LOCK: st_nx = !count_ok ? LK_SEEN : (alt ? LK_LOCK : LK_ONE);
               default: st_nx = LK_IDLE;
            endcase
         end else if (count_ok) begin
            st_nx  = LK_IDLE;
            idx_nx = '0;
         end else begin
            idx_nx = idx + 1'b1;
         end
      end
   end

   assign lock_nx   = (st_nx == LK_LOCK);
   assign tooth_sum = ANGLE_W'(half_nx ? cfg_teeth : '0) + ANGLE_W'(idx_nx);
   assign pos_nx    = tooth_sum << LOG_TPT;
   assign gap_lim   = ((LIM_W'(cfg_missing) + 1'b1) << LOG_TPT) - 1'b1;
   assign lim_nx    = (idx_nx == last_idx) ? gap_lim : LIM_W'(TPT - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= LK_IDLE;
         idx      <= '0;
         half     <= 1'b0;
         prev_cam <= 1'b0;
         tick_lim <= LIM_W'(TPT - 1);
      end else if (rise) begin
         state    <= st_nx;
         idx      <= idx_nx;
         half     <= half_nx;
         tick_lim <= lim_nx;
         if (gap) prev_cam <= cam;
      end
   end

   // R3: a gap with the wrong tooth count leaves the tracker unlocked
   a_r3_bad_gap_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && gap && state != LK_IDLE && !count_ok) |=> !locked);
   // R9: a surplus tooth sends the tracker back to waiting for a gap
   a_r9_overflow_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !gap && count_ok) |=> (state == LK_IDLE));
   // R4: lock is only ever gained at a gap edge
   a_r4_lock_at_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(rise && gap));
   // R6: tooth index stays inside one revolution
   a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= last_idx);
endmodule

// File: rtl/crk_tick_interp.sv
module crk_tick_interp #(
   parameter int PERIOD_W = 20,
   parameter int LOG_TPT  = 2,
   parameter int LIM_W    = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                rise,
   input  logic [PERIOD_W-1:0] ref_period,
   input  logic [LIM_W-1:0]    tick_lim,
   output logic                tick
);
   logic [PERIOD_W-1:0] step, step_eff, sub;
   logic [LIM_W-1:0]    done;
   logic                sub_end;

   assign step     = ref_period >> LOG_TPT;
   assign step_eff = (step == '0) ? PERIOD_W'(1) : step;
   assign sub_end  = (sub == step_eff - 1'b1);
   assign tick     = en & ~rise & sub_end & (done != tick_lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub  <= '0;
         done <= '0;
      end else if (rise) begin
         sub  <= '0;
         done <= '0;
      end else if (en) begin
         if (sub_end) begin
            sub <= '0;
            if (tick) done <= done + 1'b1;
         end else begin
            sub <= sub + 1'b1;
         end
      end
   end

   // R7: the tick budget of one interval is never exceeded
   a_r7_budget: assert property (@(posedge clk) disable iff (!rst_n)
      done <= tick_lim);
endmodule

// File: rtl/crk_angle_tracker.sv
module crk_angle_tracker #(
   parameter int TOOTH_W     = 7,
   parameter int LOG_TPT     = 2,
   parameter int PERIOD_W    = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           crank_tooth,
   input  logic                           cam_level,
   input  logic [TOOTH_W-1:0]             cfg_teeth,
   input  logic [TOOTH_W-1:0]             cfg_missing,
   output logic [TOOTH_W+LOG_TPT:0]       angle_ticks,
   output logic                           tick_stb,
   output logic                           sync_stopped
);
   localparam int ANGLE_W = TOOTH_W + LOG_TPT + 1;
   localparam int LIM_W   = TOOTH_W + LOG_TPT;

   generate
      if (LOG_TPT < 1 || LOG_TPT > 8) begin : g_bad_tpt
         $error("LOG_TPT out of range");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (PERIOD_W <= LOG_TPT + 1) begin : g_bad_per
         $error("PERIOD_W too narrow");
      end
      if (TOOTH_W < 2) begin : g_bad_tooth
         $error("TOOTH_W too narrow");
      end
   endgenerate

   logic                rise, gap, cam_e, locked, lock_nx, tick;
   logic [PERIOD_W-1:0] ref_period;
   logic [ANGLE_W-1:0]  pos_nx, cycle_ticks;
   logic [LIM_W-1:0]    tick_lim;

   crk_edge_timer #(.PERIOD_W(PERIOD_W), .SYNC_STAGES(SYNC_STAGES)) u_timer (
      .clk(clk), .rst_n(rst_n), .crank_in(crank_tooth), .cam_in(cam_level),
      .rise(rise), .gap(gap), .cam_at_edge(cam_e), .ref_period(ref_period));

   crk_sync_fsm #(.TOOTH_W(TOOTH_W), .LOG_TPT(LOG_TPT), .ANGLE_W(ANGLE_W),
                  .LIM_W(LIM_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .rise(rise), .gap(gap), .cam(cam_e),
      .cfg_teeth(cfg_teeth), .cfg_missing(cfg_missing), .locked(locked),
      .lock_nx(lock_nx), .pos_nx(pos_nx), .tick_lim(tick_lim));

   crk_tick_interp #(.PERIOD_W(PERIOD_W), .LOG_TPT(LOG_TPT), .LIM_W(LIM_W)) u_interp (
      .clk(clk), .rst_n(rst_n), .en(locked), .rise(rise),
      .ref_period(ref_period), .tick_lim(tick_lim), .tick(tick));

   assign sync_stopped = ~locked;
   assign cycle_ticks  = ANGLE_W'({cfg_teeth, 1'b0}) << LOG_TPT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         angle_ticks <= '0;
         tick_stb    <= 1'b0;
      end else if (rise) begin
         angle_ticks <= lock_nx ? pos_nx : '0;
         tick_stb    <= lock_nx;
      end else if (tick) begin
         angle_ticks <= angle_ticks + 1'b1;
         tick_stb    <= 1'b1;
      end else begin
         tick_stb    <= 1'b0;
      end
   end

   // R7: a locked angle stays below one full cycle
   a_r7_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_stopped |-> (angle_ticks < cycle_ticks));
   // R8: no movement while sync is stopped
   a_r8_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      sync_stopped |-> (angle_ticks == '0 && !tick_stb));
   // R11: every locked change of angle carries the strobe
   a_r11_change_strobed: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_stopped && !$stable(angle_ticks)) |-> tick_stb);
endmodule

// File: tb/tb_crk_angle_tracker.sv
module tb_crk_angle_tracker;
   localparam int CLK_PERIOD = 10;
   localparam int TW = 7;
   localparam int LT = 2;
   localparam int TPT = 1 << LT;
   localparam int TOOTH_CLK = 32;
   localparam int SS = 2;
   localparam int LAT = SS + 1;

   logic clk = 1'b0, rst_n = 1'b0, crank = 1'b0, cam = 1'b0;
   logic [TW-1:0] cfg_n = 7'd12, cfg_m = 7'd2;
   logic [TW+LT:0] angle;
   logic stb, stopped;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;
   // tooth-level model: 0 idle, 1 seen, 2 one good, 3 locked
   int m_st, m_idx, m_half, m_pc, prev_span, N, M;

   always #(CLK_PERIOD/2) clk = ~clk;

   crk_angle_tracker #(.TOOTH_W(TW), .LOG_TPT(LT), .PERIOD_W(20), .SYNC_STAGES(SS)) dut (
      .clk(clk), .rst_n(rst_n), .crank_tooth(crank), .cam_level(cam),
      .cfg_teeth(cfg_n), .cfg_missing(cfg_m), .angle_ticks(angle),
      .tick_stb(stb), .sync_stopped(stopped));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // one tooth edge followed by an interval of span tooth periods
   task automatic tooth(input int span, input bit cam_v, input string tag);
      bit g, ok_cnt;
      int old_lock, base, lim, exp;
      g = (prev_span > 1);          // R2: long interval marks a gap
      old_lock = (m_st == 3);
      crank = 1'b1;
      cam = cam_v;
      ok_cnt = (m_idx == N - M - 1);
      if (g) begin
         case (m_st)
            0: m_st = 1;
            1: m_st = ok_cnt ? 2 : 1;
            default: m_st = !ok_cnt ? 1 : ((cam_v != m_pc) ? 3 : 2);
         endcase
         m_idx = 0;
         m_half = cam_v ? 0 : 1;
         m_pc = cam_v;
      end else if (ok_cnt) begin
         m_st = 0;
         m_idx = 0;
      end else begin
         m_idx++;
      end
      base = (m_half * N + m_idx) * TPT;
      lim = (m_idx == N - M - 1) ? (M + 1) * TPT - 1 : TPT - 1;
      for (int k = 1; k <= span * TOOTH_CLK; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k == TOOTH_CLK / 2) crank = 1'b0;
         if (k == LAT - 1) begin
            // R12: nothing moves before the pipeline latency
            chk(stopped == !old_lock, "R12 sync flag early", stopped, !old_lock);
            chk(stb == 1'b0, "R12 strobe early", stb, 0);
         end
         if (k == LAT) begin
            chk(stopped == (m_st != 3), tag, stopped, m_st != 3);
            chk(stb == (m_st == 3), "R11 edge strobe", stb, m_st == 3);
            if (m_st == 3)
               chk(angle == base, (m_idx == 0) ? "R5 gap tooth angle" : "R6 tooth angle",
                   angle, base);
            else
               chk(angle == 0 && stb == 0, "R8 idle angle", angle, 0);
         end
         if (k == LAT + 1)
            chk(stb == 1'b0, "R11 one-cycle strobe", stb, 0);
         if (k >= LAT + 4 && ((k - LAT - 4) % (TOOTH_CLK / TPT)) == 0) begin
            int j;
            j = (k - LAT - 4) / (TOOTH_CLK / TPT);
            exp = (m_st == 3) ? base + ((j < lim) ? j : lim) : 0;
            chk(angle == exp, (m_st == 3) ? "R7 interpolated angle" : "R8 idle angle",
                angle, exp);
         end
      end
      prev_span = span;
   endtask

   // mode 0 normal, 1 one tooth dropped, 2 gap filled with teeth
   task automatic rev(input bit cam_v, input int start, input int mode, input string tag);
      int last;
      last = (mode == 2) ? N - 1 : N - M - 1;
      for (int p = start; p <= last; p++) begin
         int span;
         span = (p == last && mode != 2) ? M + 1 : 1;
         if (mode == 1 && p == 4) span = 2;
         if (!(mode == 1 && p == 5)) tooth(span, cam_v, tag);
      end
   endtask

   task automatic run_cfg(input int n_v, input int m_v);
      N = n_v; M = m_v;
      rst_n = 1'b0; crank = 1'b0; cam = 1'b0;
      cfg_n = TW'(n_v); cfg_m = TW'(m_v);
      m_st = 0; m_idx = 0; m_half = 0; m_pc = 0; prev_span = 1;
      repeat (4) @(negedge clk);
      chk(stopped == 1'b1, "R1 reset flag", stopped, 1);
      chk(angle == 0, "R1 reset angle", angle, 0);
      chk(stb == 1'b0, "R1 reset strobe", stb, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(stopped == 1'b1 && angle == 0, "R1 after reset", angle, 0);
      rev(1'b0, 3, 0, "R4 acquire");
      for (int r = 0; r < 6; r++) rev(r % 2 == 0, 0, 0, "R4 acquire");
      rev(1'b1, 0, 1, "R3 dropped tooth");
      for (int r = 0; r < 4; r++) rev(r % 2 == 0, 0, 0, "R3 recover");
      rev(1'b1, 0, 0, "R10 cam repeat");
      rev(1'b1, 0, 0, "R10 cam repeat");
      rev(1'b0, 0, 0, "R10 relock");
      rev(1'b1, 0, 0, "R10 relock");
      rev(1'b0, 0, 2, "R9 overflow");
      for (int r = 0; r < 5; r++) rev(r % 2 == 0, 0, 0, "R9 recover");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      run_cfg(12, 2);
      run_cfg(8, 1);
      run_cfg(10, 3);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule